// File: doc/BRIEF.md
# I2C Master Byte Engine with Acknowledge Wait

This block moves one byte at a time from a CPU onto an I2C bus as master. Software enables the interface, sets the bit order, the wait option and the clock rate in a mode register, then writes a data byte. The engine then produces eight SCL clocks carrying the byte on SDA, followed by a ninth clock for the acknowledge. During that ninth clock it releases SDA and records the level the receiver drives.

An interrupt-request flag marks the end of each stage. When wait insertion is on, the engine stops after the eighth data clock and keeps SCL low. It also raises the flag, so software can inspect or prepare before the acknowledge. Clearing the flag resumes the engine. Start and stop conditions, slave operation and arbitration are handled elsewhere.

The CPU port is a plain single-cycle write strobe with a two-bit address. Read data is registered. Registers: control at address 0 (bit 7 enable, bit 2 busy, bit 1 received acknowledge, bit 0 request flag), mode at address 1, data at address 2.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, scl_o and sda_o are 1, irq_o is 0, the control register reads 0 and every mode bit is 0.
- R2: While control bit 7 (enable) is 0, writes to the mode register are ignored and the mode register reads as 0.
- R3: While enabled, the mode register is writable and reads back with bit 7 = LSB-first order, bit 6 = wait enable, bits 5:3 = clock select, and bits 2:0 reading 0.
- R4: With mode bit 7 = 0, the byte is presented most significant bit first; SDA is valid at each SCL rising edge.
- R5: With mode bit 7 = 1, the byte is presented least significant bit first.
- R6: With wait disabled, the ninth (acknowledge) SCL clock follows the eighth data clock with no pause, and the flag stays 0 until the acknowledge clock has ended.
- R7: With wait enabled, the flag becomes 1 once the eighth SCL clock falls, and SCL then stays low with no further clock for as long as the flag remains 1.
- R8: Writing 0 to control bit 0 clears the flag and, during a wait, lets the acknowledge clock proceed; writing 1 to control bit 0 leaves the flag unchanged.
- R9: The flag, also driven on irq_o, becomes 1 after the acknowledge clock falls.
- R10: During the acknowledge clock sda_o is 1 (released), and the level of sda_i at the SCL rising edge is stored in control bit 1.
- R11: Each SCL high phase lasts 2^(CS+2) system clocks, where CS is the clock-select field.
- R12: A write to the data register while enabled and idle starts a transfer; a data write while a transfer is in progress is ignored and does not alter the byte on the wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Registered read data for cpu_addr |
| scl_o | output | 1 | SCL drive level (1 = released) |
| sda_o | output | 1 | SDA drive level (1 = released) |
| sda_i | input | 1 | SDA level seen on the bus |
| irq_o | output | 1 | Interrupt request, equal to the flag |

## Verification
The hardest situation to reach is the acknowledge wait: the engine must be parked after the eighth falling SCL edge with the flag set. Software must then touch the flag twice, once with a 1 that must not release SCL and once with a 0 that must. The stimulus enables wait mode, starts a byte, and watches SCL rising edges until eight have been seen. It then idles for many prescaler periods, confirming that SCL does not rise again before each flag write. A slave model pulls sda_i low only in the gap between the eighth and ninth rising edges, so both acknowledge and non-acknowledge values reach control bit 1.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int DATA_W   = 8;
  localparam int CKS_W    = 3;
  localparam int ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_WAIT,
    ST_ACK_LO,
    ST_ACK_HI
  } eng_state_t;

  typedef struct packed {
    logic             lsb_first;
    logic             wait_en;
    logic [CKS_W-1:0] cks;
  } mode_t;
endpackage

// File: rtl/i2cm_prescaler.sv
module i2cm_prescaler #(
  parameter int CKS_W      = 3,
  parameter int BASE_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CKS_W-1:0] cks,
  output logic             tick
);
  localparam int CNT_W = BASE_SHIFT + (1 << CKS_W);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit = (ONE << (int'(cks) + BASE_SHIFT)) - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == limit) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + ONE;
      tick  <= 1'b0;
    end
  end

  // R11: the divider period is at least four clocks, so ticks never touch
  a_r11_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/i2cm_byte_fsm.sv
module i2cm_byte_fsm
  import i2cm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] tx_byte,
  input  logic          lsb_first,
  input  logic          wait_en,
  input  logic          tick,
  input  logic          flag,
  input  logic          sda_i,
  output logic          scl_o,
  output logic          sda_o,
  output logic          busy,
  output logic          set_flag,
  output logic          ack_bit
);
  localparam int BCW = $clog2(DW);
  localparam logic [BCW-1:0] LAST = BCW'(DW - 1);

  eng_state_t    state_q;
  logic [DW-1:0] sh_q;
  logic [BCW-1:0] bit_q;
  logic          lsb_q;
  logic          wait_q;

  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      sh_q     <= '0;
      bit_q    <= '0;
      lsb_q    <= 1'b0;
      wait_q   <= 1'b0;
      scl_o    <= 1'b1;
      sda_o    <= 1'b1;
      set_flag <= 1'b0;
      ack_bit  <= 1'b0;
    end else begin
      set_flag <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            sh_q    <= tx_byte;
            bit_q   <= '0;
            lsb_q   <= lsb_first;
            wait_q  <= wait_en;
            scl_o   <= 1'b0;
            sda_o   <= lsb_first ? tx_byte[0] : tx_byte[DW-1];
            state_q <= ST_BIT_LO;
          end
        end
        ST_BIT_LO: begin
          if (tick) begin
            scl_o   <= 1'b1;
            state_q <= ST_BIT_HI;
          end
        end
        ST_BIT_HI: begin
          if (tick) begin
            scl_o <= 1'b0;
            if (bit_q == LAST) begin
              sda_o <= 1'b1;
              if (wait_q) begin
                set_flag <= 1'b1;
                state_q  <= ST_WAIT;
              end else begin
                state_q  <= ST_ACK_LO;
              end
            end else begin
              bit_q   <= bit_q + 1'b1;
              sh_q    <= lsb_q ? (sh_q >> 1) : (sh_q << 1);
              sda_o   <= lsb_q ? sh_q[1] : sh_q[DW-2];
              state_q <= ST_BIT_LO;
            end
          end
        end
        ST_WAIT: begin
          if (!flag && !set_flag) state_q <= ST_ACK_LO;
        end
        ST_ACK_LO: begin
          if (tick) begin
            scl_o   <= 1'b1;
            ack_bit <= sda_i;
            state_q <= ST_ACK_HI;
          end
        end
        ST_ACK_HI: begin
          if (tick) begin
            scl_o    <= 1'b0;
            set_flag <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7: the bus clock is parked low while waiting for software
  a_r7_wait_holds_scl: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) |-> !scl_o);

  // R8: the wait is left only after the flag has been cleared
  a_r8_wait_needs_clear: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && flag) |=> (state_q == ST_WAIT));

  // R10: SDA is released throughout the acknowledge slot
  a_r10_ack_released: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACK_LO || state_q == ST_ACK_HI) |-> sda_o);

  // R4: SDA holds still while SCL is high during data bits
  a_r4_sda_stable_high: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BIT_HI && $past(state_q) == ST_BIT_HI) |-> $stable(sda_o));
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          set_flag_i,
  input  logic          busy_i,
  input  logic          ack_bit_i,
  output mode_t         mode_o,
  output logic          flag_o,
  output logic          start_o,
  output logic [DW-1:0] tx_byte_o
);
  localparam int MODE_W = $bits(mode_t);
  localparam int PAD_W  = DW - MODE_W;

  logic en_q;
  logic wr_ctrl, wr_mode, wr_data;

  assign wr_ctrl = cpu_wr && (cpu_addr == A_CTRL);
  assign wr_mode = cpu_wr && (cpu_addr == A_MODE) && en_q;
  assign wr_data = cpu_wr && (cpu_addr == A_DATA) && en_q && !busy_i && !start_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      mode_o    <= '0;
      flag_o    <= 1'b0;
      start_o   <= 1'b0;
      tx_byte_o <= '0;
    end else begin
      start_o <= 1'b0;
      if (wr_ctrl) en_q <= cpu_wdata[DW-1];
      if (wr_mode) mode_o <= mode_t'(cpu_wdata[DW-1:PAD_W]);
      if (set_flag_i)                     flag_o <= 1'b1;
      else if (wr_ctrl && !cpu_wdata[0])  flag_o <= 1'b0;
      if (wr_data) begin
        tx_byte_o <= cpu_wdata;
        start_o   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
    end else begin
      case (cpu_addr)
        A_CTRL:  cpu_rdata <= {en_q, {(DW-4){1'b0}}, busy_i, ack_bit_i, flag_o};
        A_MODE:  cpu_rdata <= en_q ? {mode_o, {PAD_W{1'b0}}} : '0;
        A_DATA:  cpu_rdata <= tx_byte_o;
        default: cpu_rdata <= '0;
      endcase
    end
  end

  // R2: the mode register cannot change while the interface is disabled
  a_r2_mode_locked: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> $stable(mode_o));

  // R9: the flag only rises when the engine asks for it
  a_r9_flag_source: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(set_flag_i));

  // R12: a start request is a single-cycle pulse
  a_r12_single_start: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int AW         = ADDR_W,
  parameter int DW         = DATA_W,
  parameter int CW         = CKS_W,
  parameter int BASE_SHIFT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          scl_o,
  output logic          sda_o,
  input  logic          sda_i,
  output logic          irq_o
);
  mode_t         mode;
  logic          flag, start, busy, set_flag, ack_bit, tick;
  logic [DW-1:0] tx_byte;

  i2cm_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata),
    .set_flag_i(set_flag), .busy_i(busy), .ack_bit_i(ack_bit),
    .mode_o(mode), .flag_o(flag), .start_o(start), .tx_byte_o(tx_byte)
  );

  i2cm_prescaler #(.CKS_W(CW), .BASE_SHIFT(BASE_SHIFT)) u_presc (
    .clk(clk), .rst(rst), .run(busy), .cks(mode.cks), .tick(tick)
  );

  i2cm_byte_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst(rst),
    .start(start), .tx_byte(tx_byte),
    .lsb_first(mode.lsb_first), .wait_en(mode.wait_en),
    .tick(tick), .flag(flag), .sda_i(sda_i),
    .scl_o(scl_o), .sda_o(sda_o), .busy(busy),
    .set_flag(set_flag), .ack_bit(ack_bit)
  );

  assign irq_o = flag;
endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic       scl_o, sda_o, sda_i, irq_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int rises = 0;
  int hi_start = 0;
  int last_hi = 0;
  logic       prev_scl = 1'b1;
  logic [8:0] cap_sda;
  logic [8:0] cap_irq;
  logic       slave_ack = 1'b1;
  logic [7:0] rv;

  always #4 clk = ~clk;

  assign sda_i = sda_o & ~(slave_ack && rises == 8);

  i2c_byte_master u_dut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i), .irq_o(irq_o)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    prev_scl <= scl_o;
    if (scl_o && !prev_scl) begin
      if (rises < 9) begin
        cap_sda[rises] <= sda_o;
        cap_irq[rises] <= irq_o;
      end
      rises <= rises + 1;
      hi_start <= cyc;
    end
    if (!scl_o && prev_scl && !rst) last_hi <= cyc - hi_start;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    @(negedge clk);
    d = cpu_rdata;
  endtask

  task automatic wait_rises(input int n);
    for (int i = 0; i < 20000 && rises < n; i++) @(negedge clk);
  endtask

  task automatic finish_byte();
    wait_rises(9);
    for (int i = 0; i < 2000 && !irq_o; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] msb_byte(input logic [8:0] c);
    return {c[0], c[1], c[2], c[3], c[4], c[5], c[6], c[7]};
  endfunction

  task automatic t_reset();
    check("R1 scl", scl_o, 1);
    check("R1 sda", sda_o, 1);
    check("R1 irq", irq_o, 0);
    rd(2'd0, rv); check("R1 ctrl", rv, 0);
    rd(2'd1, rv); check("R1 mode", rv, 0);
  endtask

  task automatic t_mode_access();
    wr(2'd1, 8'hF8);
    rd(2'd1, rv); check("R2 mode read disabled", rv, 0);
    wr(2'd0, 8'h80);
    rd(2'd1, rv); check("R2 disabled write ignored", rv, 0);
    wr(2'd1, 8'hFF);
    rd(2'd1, rv); check("R3 mode readback", rv, 8'hF8);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_msb_nowait();
    rises = 0; slave_ack = 1'b1;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hA5);
    finish_byte();
    check("R4 msb-first byte", msb_byte(cap_sda), 8'hA5);
    check("R6 nine clocks", rises, 9);
    check("R6 no flag before ack", cap_irq[8], 0);
    check("R11 high time cs0", last_hi, 4);
    check("R9 flag after ack", irq_o, 1);
    check("R10 ack sda released", cap_sda[8], 1);
    rd(2'd0, rv); check("R10 ack stored low", rv[1], 0);
    wr(2'd0, 8'h80);
    check("R8 clear by zero", irq_o, 0);
  endtask

  task automatic t_lsb_nack();
    rises = 0; slave_ack = 1'b0;
    wr(2'd1, 8'h98);
    wr(2'd2, 8'h2C);
    finish_byte();
    check("R5 lsb-first byte", cap_sda[7:0], 8'h2C);
    check("R11 high time cs3", last_hi, 32);
    rd(2'd0, rv); check("R10 nack stored high", rv[1], 1);
    wr(2'd0, 8'h80);
  endtask

  task automatic t_wait();
    rises = 0; slave_ack = 1'b1;
    wr(2'd1, 8'h48);
    wr(2'd2, 8'h3C);
    wait_rises(8);
    check("R7 no flag at 8th rise", cap_irq[7], 0);
    repeat (300) @(negedge clk);
    check("R7 flag in wait", irq_o, 1);
    check("R7 scl low in wait", scl_o, 0);
    check("R7 no ninth clock", rises, 8);
    wr(2'd0, 8'h81);
    repeat (200) @(negedge clk);
    check("R8 write one keeps flag", irq_o, 1);
    check("R8 still parked", rises, 8);
    wr(2'd0, 8'h80);
    check("R8 flag cleared", irq_o, 0);
    finish_byte();
    check("R8 ack clock after clear", rises, 9);
    check("R9 flag after ack in wait mode", irq_o, 1);
    check("R4 byte in wait mode", msb_byte(cap_sda), 8'h3C);
    wr(2'd0, 8'h80);
  endtask

  task automatic t_busy_write();
    rises = 0; slave_ack = 1'b1;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h81);
    wait_rises(3);
    wr(2'd2, 8'h00);
    rd(2'd0, rv); check("R12 busy bit", rv[2], 1);
    finish_byte();
    check("R12 busy write ignored", msb_byte(cap_sda), 8'h81);
    rd(2'd2, rv); check("R12 data unchanged", rv, 8'h81);
    wr(2'd0, 8'h80);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode_access();
    t_msb_nowait();
    t_lsb_nack();
    t_wait();
    t_busy_write();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule